// File: doc/BRIEF.md
# Level-Testable Group Generate/Propagate Tree

This block is a binary reduction tree of generate/propagate combiner nodes, the kind that forms the prefix section of a carry-lookahead adder. It takes 2^LEVELS leaf pairs, each a 2-bit value holding a generate bit and a propagate bit, and reduces them level by level to a single root pair. Each node can be switched into an identity mode, in which it outputs the bitwise XOR of its two inputs. All nodes on one level share a single mode bit.

The identity mode makes the tree testable one level at a time. To test a level, all of its nodes are given the same input pattern and every level nearer the root is placed in identity mode. A healthy tree then yields a zero root, because equal values cancel in the XOR. A single faulty node leaves a nonzero difference that reaches the root. The number of test patterns therefore grows with the depth of the tree, not with its node count. The root value and a mismatch flag are registered. A debug override can replace any one node's output with a chosen value, which gives a way to inject a fault.

Top module: `gp_level_tree`

## Requirements
- R1: Every value is 2 bits: bit 1 is generate (G) and bit 0 is propagate (P). Leaf j sits at `leaves_i[2j+1:2j]`. Node i on level l (level 0 is the root) takes its low input from child 2i and its high input from child 2i+1 of the next level down. The deepest level takes these children from the leaves.
- R2: When a node's mode bit is 0 it combines its inputs: G = Ghi | (Phi & Glo), and P = Phi & Plo.
- R3: When a node's mode bit is 1 it outputs hi XOR lo. That output is 0 exactly when the two inputs are equal, so a root in this mode with two identical subtrees gives 0.
- R4: Bit l of `mode_i` selects the mode of every node on level l. Bit 0 is the root level.
- R5: `root_o` and `mismatch_o` show the result of the inputs present at the previous rising clock edge. `rst_n` is an asynchronous, active-low reset. While it is low, both outputs are 0.
- R6: `mismatch_o` is 1 exactly when, at the capturing edge, `mode_i[0]` was 1 and the root value was nonzero. When `mode_i[0]` was 0, `mismatch_o` is 0.
- R7: While `ovr_en_i` is 1, the node at level `ovr_lvl_i` and index `ovr_idx_i` outputs `ovr_val_i` in place of its computed value. Its ancestors treat this value like any other node output.
- R8: Consider any level k and any of the 16 (hi, lo) patterns applied to all of its nodes. Levels 0..k-1 are in identity mode and level k combines. A fault-free tree then gives a root of 0 and no mismatch (for k = 0, the root equals the combine of the pattern). A single wrong node output on level k with k > 0 raises `mismatch_o`.
- R9: An override whose index is not a node of the named level, or whose level is not a tree level, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| leaves_i | input | 2*2^LEVELS | Leaf (G,P) pairs, leaf j at bits 2j+1:2j |
| mode_i | input | LEVELS | Per-level mode, 1 = identity (XOR), bit 0 = root |
| ovr_en_i | input | 1 | Enables the node output override |
| ovr_lvl_i | input | max(1,clog2(LEVELS)) | Level of the overridden node |
| ovr_idx_i | input | LEVELS-1 | Index of the overridden node within its level |
| ovr_val_i | input | 2 | Value forced onto the overridden node |
| root_o | output | 2 | Registered root (G,P) value |
| mismatch_o | output | 1 | Registered flag: root in identity mode and nonzero |

## Verification
A node whose value is wrong, whether it has the wrong combine or XOR behaviour or a stuck mode bit, shows up as a wrong `root_o` one clock after the inputs are applied. In a level test it appears as `mismatch_o` rising in that same cycle. The bench injects one wrong node output with the override, at each level and under each of the 16 patterns, and expects the flag on the next sample. Miswiring of a child is caught by the hand-worked normal-mode vectors, which use asymmetric leaf patterns.

// File: rtl/gp_tree_pkg.sv
package gp_tree_pkg;

    typedef logic [1:0] gp_t;

    typedef enum logic {
        MODE_COMBINE  = 1'b0,
        MODE_IDENTITY = 1'b1
    } node_mode_e;

    // Bit 1 is generate, bit 0 is propagate; hi is the more significant group
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r[1] = hi[1] | (hi[0] & lo[1]);
        r[0] = hi[0] & lo[0];
        return r;
    endfunction

endpackage

// File: rtl/gp_tree_node.sv
module gp_tree_node
    import gp_tree_pkg::*;
(
    input  gp_t        hi_i,
    input  gp_t        lo_i,
    input  logic       mode_i,
    input  logic       ovr_i,
    input  gp_t        ovr_val_i,
    output gp_t        val_o
);

    node_mode_e mode_sel;
    gp_t        func_val;

    assign mode_sel = node_mode_e'(mode_i);

    always_comb begin
        unique case (mode_sel)
            MODE_COMBINE:  func_val = gp_merge(hi_i, lo_i);
            MODE_IDENTITY: func_val = hi_i ^ lo_i;
            default:       func_val = '0;
        endcase
    end

    assign val_o = ovr_i ? ovr_val_i : func_val;

endmodule

// File: rtl/gp_tree_core.sv
module gp_tree_core
    import gp_tree_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    parameter int IDX_W  = (LEVELS > 1) ? LEVELS - 1 : 1
) (
    input  logic [2*(1<<LEVELS)-1:0] leaves_i,
    input  logic [LEVELS-1:0]        mode_i,
    input  logic                     ovr_en_i,
    input  logic [LVL_W-1:0]         ovr_lvl_i,
    input  logic [IDX_W-1:0]         ovr_idx_i,
    input  gp_t                      ovr_val_i,
    output gp_t                      root_o
);

    localparam int LEAVES = 1 << LEVELS;

    // Heap numbering: root is 1, children of h are 2h (low) and 2h+1 (high)
    gp_t hv [1:2*LEAVES-1];

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        assign hv[LEAVES+j] = leaves_i[2*j +: 2];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar i = 0; i < (1 << l); i++) begin : g_node
            localparam int H = (1 << l) + i;
            logic hit;
            assign hit = ovr_en_i
                       && (ovr_lvl_i == LVL_W'(l))
                       && (ovr_idx_i == IDX_W'(i));
            gp_tree_node u_node (
                .hi_i      (hv[2*H+1]),
                .lo_i      (hv[2*H]),
                .mode_i    (mode_i[l]),
                .ovr_i     (hit),
                .ovr_val_i (ovr_val_i),
                .val_o     (hv[H])
            );
        end
    end

    assign root_o = hv[1];

endmodule

// File: rtl/gp_tree_out.sv
module gp_tree_out
    import gp_tree_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  gp_t  root_d,
    input  logic root_ident,
    output gp_t  root_o,
    output logic mismatch_o
);

    logic mismatch_d;

    assign mismatch_d = root_ident && (root_d != 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_o     <= '0;
            mismatch_o <= 1'b0;
        end else begin
            root_o     <= root_d;
            mismatch_o <= mismatch_d;
        end
    end

endmodule

// File: rtl/gp_level_tree.sv
module gp_level_tree
    import gp_tree_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    parameter int IDX_W  = (LEVELS > 1) ? LEVELS - 1 : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*(1<<LEVELS)-1:0] leaves_i,
    input  logic [LEVELS-1:0]        mode_i,
    input  logic                     ovr_en_i,
    input  logic [LVL_W-1:0]         ovr_lvl_i,
    input  logic [IDX_W-1:0]         ovr_idx_i,
    input  logic [1:0]               ovr_val_i,
    output logic [1:0]               root_o,
    output logic                     mismatch_o
);

    gp_t root_comb;

    gp_tree_core #(
        .LEVELS (LEVELS),
        .LVL_W  (LVL_W),
        .IDX_W  (IDX_W)
    ) u_core (
        .leaves_i  (leaves_i),
        .mode_i    (mode_i),
        .ovr_en_i  (ovr_en_i),
        .ovr_lvl_i (ovr_lvl_i),
        .ovr_idx_i (ovr_idx_i),
        .ovr_val_i (ovr_val_i),
        .root_o    (root_comb)
    );

    gp_tree_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_d     (root_comb),
        .root_ident (mode_i[0]),
        .root_o     (root_o),
        .mismatch_o (mismatch_o)
    );

endmodule

// File: rtl/gp_level_tree_chk.sv
module gp_level_tree_chk #(
    parameter int LEVELS = 3,
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    parameter int IDX_W  = (LEVELS > 1) ? LEVELS - 1 : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [2*(1<<LEVELS)-1:0] leaves_i,
    input logic [LEVELS-1:0]        mode_i,
    input logic                     ovr_en_i,
    input logic [LVL_W-1:0]         ovr_lvl_i,
    input logic [IDX_W-1:0]         ovr_idx_i,
    input logic [1:0]               ovr_val_i,
    input logic [1:0]               root_o,
    input logic                     mismatch_o
);

    localparam int LEAVES = 1 << LEVELS;

    logic all_equal;
    assign all_equal = (leaves_i == {LEAVES{leaves_i[1:0]}});

    // R6: a raised flag always goes with a nonzero root
    assert_flag_needs_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> (root_o != 2'b00));

    // R6: root not in identity mode never flags
    assert_no_flag_when_combining_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[0] |=> !mismatch_o);

    // R3: identical halves cancel at an identity root
    assert_equal_halves_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[0] && all_equal && !ovr_en_i) |=> (root_o == 2'b00 && !mismatch_o));

    // R2: the combine function is idempotent over uniform leaves
    assert_uniform_combine_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == '0 && all_equal && !ovr_en_i) |=> (root_o == $past(leaves_i[1:0])));

    // R7: overriding the root shows the forced value directly
    assert_root_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en_i && ovr_lvl_i == '0 && ovr_idx_i == '0) |=> (root_o == $past(ovr_val_i)));

endmodule

bind gp_level_tree gp_level_tree_chk #(
    .LEVELS (LEVELS),
    .LVL_W  (LVL_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .leaves_i   (leaves_i),
    .mode_i     (mode_i),
    .ovr_en_i   (ovr_en_i),
    .ovr_lvl_i  (ovr_lvl_i),
    .ovr_idx_i  (ovr_idx_i),
    .ovr_val_i  (ovr_val_i),
    .root_o     (root_o),
    .mismatch_o (mismatch_o)
);

// File: tb/test_gp_level_tree.sv
`timescale 1ns/1ps
module test_gp_level_tree;

    localparam int LEVELS = 3;
    localparam int LEAVES = 1 << LEVELS;
    localparam int LVL_W  = 2;
    localparam int IDX_W  = 2;

    // {mode[2:0], leaves[15:0], root[1:0], mismatch}
    localparam int NVEC = 7;
    localparam logic [21:0] VEC [NVEC] = '{
        {3'b000, 16'h5555, 2'b01, 1'b0},
        {3'b000, 16'h5556, 2'b10, 1'b0},
        {3'b000, 16'h5516, 2'b00, 1'b0},
        {3'b111, 16'h4039, 2'b01, 1'b1},
        {3'b001, 16'hFFFF, 2'b00, 1'b0},
        {3'b001, 16'h5655, 2'b11, 1'b1},
        {3'b110, 16'h0003, 2'b00, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2*LEAVES-1:0]  leaves_i = '0;
    logic [LEVELS-1:0]    mode_i = '0;
    logic                 ovr_en_i = 1'b0;
    logic [LVL_W-1:0]     ovr_lvl_i = '0;
    logic [IDX_W-1:0]     ovr_idx_i = '0;
    logic [1:0]           ovr_val_i = '0;
    logic [1:0]           root_o;
    logic                 mismatch_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gp_level_tree #(.LEVELS(LEVELS)) i_gp_level_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .leaves_i   (leaves_i),
        .mode_i     (mode_i),
        .ovr_en_i   (ovr_en_i),
        .ovr_lvl_i  (ovr_lvl_i),
        .ovr_idx_i  (ovr_idx_i),
        .ovr_val_i  (ovr_val_i),
        .root_o     (root_o),
        .mismatch_o (mismatch_o)
    );

    function automatic logic [1:0] ref_merge(input logic [1:0] hi, input logic [1:0] lo);
        return {hi[1] | (hi[0] & lo[1]), hi[0] & lo[0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive on a falling edge, sample on the following falling edge
    task automatic apply(input logic [LEVELS-1:0] m, input logic [2*LEAVES-1:0] lv,
                         input logic oe, input int ol, input int oi, input logic [1:0] ov);
        @(negedge clk);
        mode_i    = m;
        leaves_i  = lv;
        ovr_en_i  = oe;
        ovr_lvl_i = LVL_W'(ol);
        ovr_idx_i = IDX_W'(oi);
        ovr_val_i = ov;
        @(negedge clk);
    endtask

    // Leaves that give every level-k node the pair (hi=a, lo=b) with deeper levels in XOR mode
    function automatic logic [2*LEAVES-1:0] level_leaves(input int k, input logic [1:0] a,
                                                         input logic [1:0] b);
        logic [2*LEAVES-1:0] v;
        int half;
        v = '0;
        half = 1 << (LEVELS - k - 1);
        for (int j = 0; j < LEAVES; j++) begin
            if (j % (2*half) == 0)    v[2*j +: 2] = b;
            else if (j % (2*half) == half) v[2*j +: 2] = a;
        end
        return v;
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        repeat (3) @(negedge clk);
        check("R5 reset root", root_o, 0);
        check("R5 reset flag", mismatch_o, 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R6: table of hand-worked vectors
        for (int n = 0; n < NVEC; n++) begin
            apply(VEC[n][21:19], VEC[n][18:3], 1'b0, 0, 0, 2'b00);
            check("R2/R3/R4 table root", root_o, VEC[n][2:1]);
            check("R6 table flag", mismatch_o, VEC[n][0]);
        end

        // R8: level tests with and without one injected wrong node
        for (int k = 0; k < LEVELS; k++) begin
            for (int p = 0; p < 16; p++) begin
                logic [1:0] a, b, good;
                logic [LEVELS-1:0] m;
                a = p[3:2];
                b = p[1:0];
                good = ref_merge(a, b);
                m = '1;
                m[k] = 1'b0;
                apply(m, level_leaves(k, a, b), 1'b0, 0, 0, 2'b00);
                check("R8 clean root", root_o, (k == 0) ? good : 2'b00);
                check("R8 clean flag", mismatch_o, 0);
                apply(m, level_leaves(k, a, b), 1'b1, k, (1 << k) - 1, good ^ 2'b01);
                if (k == 0)
                    check("R8 R7 root fault", root_o, good ^ 2'b01);
                else
                    check("R8 fault flag", mismatch_o, 1);
            end
        end

        // R7: override a deepest node in normal mode
        apply(3'b000, 16'h5555, 1'b1, 2, 3, 2'b00);
        check("R7 deep override", root_o, 0);
        // R9: index outside level 0 and level outside the tree have no effect
        apply(3'b000, 16'h5555, 1'b1, 0, 1, 2'b10);
        check("R9 bad index", root_o, 1);
        apply(3'b000, 16'h5555, 1'b1, 3, 0, 2'b10);
        check("R9 bad level", root_o, 1);

        // R5: asynchronous reset clears a nonzero result
        apply(3'b001, 16'h5655, 1'b0, 0, 0, 2'b00);
        check("R6 pre-reset flag", mismatch_o, 1);
        #1 rst_n = 1'b0;
        #1;
        check("R5 async root", root_o, 0);
        check("R5 async flag", mismatch_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule